// File: doc/BRIEF.md
# Target-Side Request Time-Out Monitor

This block sits between an interconnect and one attached peripheral and watches every request it passes on. A request from the initiator goes either to the agent itself (a local register read) or on to the target. A target request is accepted from the initiator, presented to the target as a command, and completed when the target sends its response back. While such a request is outstanding, the block counts pulses of one time-base tick. The tick is chosen from four broadcast ticks by a 3-bit select input. If the response is still missing when enough ticks have been counted, the request times out.

On a time-out the agent aborts the outstanding request and answers it with an error response. It sets a sticky status bit, raises a one-cycle error event toward the upstream logic and enters an error state. In the error state it cuts off its target: it presents no more commands and silently absorbs any late target response. Every new target request is answered with an error response, while local register reads still complete normally. Only the agent soft-reset input or the global reset leaves this state. Software is expected to reset the peripheral before it pulses the agent reset.

All four data paths use valid/ready. A transfer happens on a clock edge where both valid and ready are high. Once a valid is raised, it and its data stay unchanged until that transfer takes place. The only exception is a time-out, which withdraws a command the target has not yet taken. The initiator may hold off a response for as long as it likes. The agent takes one request at a time and raises its request ready only while it is idle.

Top module: `tmo_agent`

## Requirements
- R1: During and right after reset, up_req_ready is 1, while up_rsp_valid, dn_cmd_valid, tmo_sticky and tmo_irq are all 0.
- R2: A target request accepted while the agent is not in the error state appears on dn_cmd_valid in the next cycle, with dn_cmd_data equal to the request data. Command valid and data then stay stable until dn_cmd_ready is seen, unless a time-out occurs first.
- R3: A target response that arrives while the agent is waiting for it drives up_rsp_valid in the next cycle, with up_rsp_err=0 and up_rsp_data equal to dn_rsp_data. The response valid, error flag and data stay stable until up_rsp_ready is 1.
- R4: A local request (up_req_local=1) never reaches the target and is answered in the next cycle with up_rsp_err=0. Bits [2:0] of the answer hold tick_sel, bit 3 holds tmo_sticky and all other bits are 0. This holds in the error state as well.
- R5: tick_sel values 1, 2, 3 and 4 select tick_in[0], tick_in[1], tick_in[2] and tick_in[3]. The value 0, and the unused values 5 to 7, disable time-out detection.
- R6: A target request times out on the clock edge where the second selected tick is counted. Ticks are counted from the edge after acceptance up to the response handshake. The counting starts afresh for each request. On a time-out, dn_cmd_valid drops and the initiator receives up_rsp_valid with up_rsp_err=1 and data 0 in the next cycle.
- R7: If the target response arrives in the same cycle as the tick that would cause the time-out, the response wins. It is forwarded with up_rsp_err=0, and no time-out occurs.
- R8: On a time-out, tmo_sticky rises and stays high, and tmo_irq is high for exactly one cycle. Both first show in the same cycle as the error response.
- R9: In the error state, dn_cmd_valid stays 0 and dn_rsp_ready is held 1. Target responses never reach the initiator. Every target request is answered with up_rsp_err=1 in the cycle after it is accepted.
- R10: A cycle with agent_srst=1 returns the agent to its reset state and clears tmo_sticky and the error state. After that, target requests are forwarded normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| up_req_valid | input | 1 | Initiator request valid |
| up_req_ready | output | 1 | Agent can take a request |
| up_req_local | input | 1 | Request addresses the agent's own registers |
| up_req_data | input | DATA_W | Request payload |
| up_rsp_valid | output | 1 | Response to initiator valid |
| up_rsp_ready | input | 1 | Initiator takes the response |
| up_rsp_err | output | 1 | Response is an error |
| up_rsp_data | output | DATA_W | Response payload |
| dn_cmd_valid | output | 1 | Command to target valid |
| dn_cmd_ready | input | 1 | Target takes the command |
| dn_cmd_data | output | DATA_W | Command payload |
| dn_rsp_valid | input | 1 | Target response valid |
| dn_rsp_ready | output | 1 | Agent takes a target response |
| dn_rsp_data | input | DATA_W | Target response payload |
| tick_in | input | N_BASE | Broadcast periodic time-base pulses |
| tick_sel | input | SEL_W | Time-base select, 0 = disabled |
| agent_srst | input | 1 | Synchronous agent soft reset |
| tmo_sticky | output | 1 | Sticky time-out status |
| tmo_irq | output | 1 | One-cycle time-out error event |

## Verification
Two events can land on the same clock edge: the target response that completes a request, and the second selected tick that would time it out. The bench provokes this with the fastest tick. It waits until one tick has been counted while the response is outstanding, and then drives the target response in exactly the cycle in which the next tick is high. The outcome is judged by a clean forwarded response, a low sticky bit and no event pulse. Acceptance of the command in the same cycle as a time-out tick is covered by the per-clock model comparison: there the time-out wins, because acceptance does not end the count.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_WAIT = 2'd2,
    PH_RESP = 2'd3
  } ph_t;
endpackage

// File: rtl/tmo_tick_sel.sv
module tmo_tick_sel #(
  parameter int N_BASE = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BASE-1:0] tick_in,
  input  logic [SEL_W-1:0]  tick_sel,
  output logic              tick
);
  logic [N_BASE-1:0] hit;

  for (genvar k = 0; k < N_BASE; k++) begin : g_base
    assign hit[k] = tick_in[k] && (tick_sel == SEL_W'(k + 1));
  end

  assign tick = |hit;

  AST_TICK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (tick_sel != '0 && tick_sel <= SEL_W'(N_BASE))); // R5
endmodule

// File: rtl/tmo_pend_cnt.sv
module tmo_pend_cnt #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pending,
  input  logic tick,
  output logic fire
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire = pending && tick && !clr && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || !pending || fire) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LIMIT)); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/tmo_agent.sv
module tmo_agent #(
  parameter int DATA_W = 16,
  parameter int N_BASE = 4,
  parameter int SEL_W  = 3,
  parameter int LIMIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_local,
  input  logic [DATA_W-1:0] up_req_data,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic              up_rsp_err,
  output logic [DATA_W-1:0] up_rsp_data,
  output logic              dn_cmd_valid,
  input  logic              dn_cmd_ready,
  output logic [DATA_W-1:0] dn_cmd_data,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_data,
  input  logic [N_BASE-1:0] tick_in,
  input  logic [SEL_W-1:0]  tick_sel,
  input  logic              agent_srst,
  output logic              tmo_sticky,
  output logic              tmo_irq
);
  import tmo_pkg::*;

  ph_t               ph_q;
  logic              sticky_q;
  logic              irq_q;
  logic              rerr_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] loc_word;
  logic              tick;
  logic              fire;
  logic              pending;
  logic              done_rsp;

  tmo_tick_sel #(.N_BASE(N_BASE), .SEL_W(SEL_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .tick_sel (tick_sel),
    .tick     (tick)
  );

  assign pending  = (ph_q == PH_CMD) || (ph_q == PH_WAIT);
  assign done_rsp = (ph_q == PH_WAIT) && dn_rsp_valid;

  tmo_pend_cnt #(.LIMIT(LIMIT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (done_rsp || agent_srst),
    .pending (pending),
    .tick    (tick),
    .fire    (fire)
  );

  always_comb begin
    loc_word = '0;
    loc_word[SEL_W-1:0] = tick_sel;
    loc_word[SEL_W] = sticky_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      sticky_q <= 1'b0;
      irq_q    <= 1'b0;
      rerr_q   <= 1'b0;
      rdata_q  <= '0;
      cmd_q    <= '0;
    end else if (agent_srst) begin
      ph_q     <= PH_IDLE;
      sticky_q <= 1'b0;
      irq_q    <= 1'b0;
      rerr_q   <= 1'b0;
      rdata_q  <= '0;
      cmd_q    <= '0;
    end else begin
      irq_q <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (up_req_valid) begin
            if (up_req_local) begin
              ph_q    <= PH_RESP;
              rerr_q  <= 1'b0;
              rdata_q <= loc_word;
            end else if (sticky_q) begin
              ph_q    <= PH_RESP;
              rerr_q  <= 1'b1;
              rdata_q <= '0;
            end else begin
              ph_q  <= PH_CMD;
              cmd_q <= up_req_data;
            end
          end
        end
        PH_CMD, PH_WAIT: begin
          if (done_rsp) begin
            ph_q    <= PH_RESP;
            rerr_q  <= 1'b0;
            rdata_q <= dn_rsp_data;
          end else if (fire) begin
            ph_q     <= PH_RESP;
            rerr_q   <= 1'b1;
            rdata_q  <= '0;
            sticky_q <= 1'b1;
            irq_q    <= 1'b1;
          end else if (ph_q == PH_CMD && dn_cmd_ready) begin
            ph_q <= PH_WAIT;
          end
        end
        default: begin
          if (up_rsp_ready) ph_q <= PH_IDLE;
        end
      endcase
    end
  end

  assign up_req_ready = (ph_q == PH_IDLE);
  assign up_rsp_valid = (ph_q == PH_RESP);
  assign up_rsp_err   = rerr_q;
  assign up_rsp_data  = rdata_q;
  assign dn_cmd_valid = (ph_q == PH_CMD);
  assign dn_cmd_data  = cmd_q;
  assign dn_rsp_ready = (ph_q == PH_WAIT) || sticky_q;
  assign tmo_sticky   = sticky_q;
  assign tmo_irq      = irq_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_cmd_valid && !dn_cmd_ready && !fire && !agent_srst) |=> (dn_cmd_valid && $stable(dn_cmd_data))); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready && !agent_srst) |=> (up_rsp_valid && $stable(up_rsp_data) && $stable(up_rsp_err))); // R3
  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |=> !tmo_irq); // R8
  AST_EVT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> (tmo_sticky && up_rsp_valid && up_rsp_err)); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sticky && !agent_srst) |=> tmo_sticky); // R8
  AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_sticky |-> (!dn_cmd_valid && dn_rsp_ready)); // R9
  AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    agent_srst |=> (!tmo_sticky && up_req_ready && !tmo_irq)); // R10
endmodule

// File: tb/tmo_agent_test.sv
module tmo_agent_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req_valid = 1'b0, up_req_local = 1'b0, up_rsp_ready = 1'b1;
  logic [DW-1:0] up_req_data = '0, dn_rsp_data = '0;
  logic dn_cmd_ready = 1'b0, dn_rsp_valid = 1'b0, agent_srst = 1'b0;
  logic [3:0] tick_in = '0;
  logic [2:0] tick_sel = 3'd2;
  logic up_req_ready, up_rsp_valid, up_rsp_err, dn_cmd_valid, dn_rsp_ready;
  logic tmo_sticky, tmo_irq;
  logic [DW-1:0] up_rsp_data, dn_cmd_data;

  tmo_agent uut (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_req_local(up_req_local), .up_req_data(up_req_data),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_err(up_rsp_err), .up_rsp_data(up_rsp_data),
    .dn_cmd_valid(dn_cmd_valid), .dn_cmd_ready(dn_cmd_ready), .dn_cmd_data(dn_cmd_data),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready), .dn_rsp_data(dn_rsp_data),
    .tick_in(tick_in), .tick_sel(tick_sel), .agent_srst(agent_srst),
    .tmo_sticky(tmo_sticky), .tmo_irq(tmo_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // time-base ticks: base k has period 8 * 4^k cycles
  always @(posedge clk) begin
    #2;
    for (int k = 0; k < 4; k++) begin
      int per;
      per = 8 << (2 * k);
      tick_in[k] = ((cyc % per) == per - 1);
    end
  end

  // behavioural reference model
  int m_ph = 0;       // 0 idle, 1 command out, 2 awaiting response, 3 answering
  int m_ticks = 0;
  bit m_err = 0, m_evt = 0, m_rerr = 0;
  logic [DW-1:0] m_rspd = '0, m_cmdd = '0;

  always @(posedge clk) begin
    bit tk;
    if (!rst_n || agent_srst) begin
      m_ph = 0; m_ticks = 0; m_err = 0; m_evt = 0; m_rerr = 0; m_rspd = '0; m_cmdd = '0;
    end else begin
      tk = (tick_sel >= 3'd1 && tick_sel <= 3'd4) ? tick_in[tick_sel - 3'd1] : 1'b0;
      m_evt = 0;
      if (m_ph == 0) begin
        if (up_req_valid) begin
          if (up_req_local) begin
            m_ph = 3; m_rerr = 0; m_rspd = {12'd0, m_err, tick_sel};
          end else if (m_err) begin
            m_ph = 3; m_rerr = 1; m_rspd = '0;
          end else begin
            m_ph = 1; m_cmdd = up_req_data; m_ticks = 0;
          end
        end
      end else if (m_ph == 1 || m_ph == 2) begin
        if (m_ph == 2 && dn_rsp_valid) begin
          m_ph = 3; m_rerr = 0; m_rspd = dn_rsp_data;
        end else begin
          if (tk) m_ticks = m_ticks + 1;
          if (m_ticks >= 2) begin
            m_err = 1; m_evt = 1; m_ph = 3; m_rerr = 1; m_rspd = '0;
          end else if (m_ph == 1 && dn_cmd_ready) begin
            m_ph = 2;
          end
        end
      end else begin
        if (up_rsp_ready) m_ph = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // per-clock comparison against the model
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R2 up_req_ready", up_req_ready, m_ph == 0);
      chk("R2 dn_cmd_valid", dn_cmd_valid, m_ph == 1);
      if (m_ph == 1) chk("R2 dn_cmd_data", dn_cmd_data, m_cmdd);
      chk("R3 up_rsp_valid", up_rsp_valid, m_ph == 3);
      if (m_ph == 3) begin
        chk("R6 up_rsp_err", up_rsp_err, m_rerr);
        chk("R3 up_rsp_data", up_rsp_data, m_rspd);
      end
      chk("R9 dn_rsp_ready", dn_rsp_ready, (m_ph == 2) || m_err);
      chk("R8 tmo_sticky", tmo_sticky, m_err);
      chk("R8 tmo_irq", tmo_irq, m_evt);
    end
  end

  bit cmd_seen = 0;
  always @(negedge clk) if (dn_cmd_valid) cmd_seen = 1;

  task automatic send(input bit loc, input logic [DW-1:0] d, output int acc_cyc);
    @(negedge clk);
    while (!up_req_ready) @(negedge clk);
    up_req_valid = 1; up_req_local = loc; up_req_data = d;
    acc_cyc = cyc;
    @(negedge clk);
    up_req_valid = 0; up_req_local = 0;
  endtask

  task automatic wait_rsp(input int limit);
    int n;
    n = 0;
    while (!up_rsp_valid && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic target_reply(input logic [DW-1:0] d);
    dn_rsp_data = d; dn_rsp_valid = 1;
    @(negedge clk);
    dn_rsp_valid = 0;
  endtask

  task automatic accept_cmd();
    while (!dn_cmd_valid) @(negedge clk);
    dn_cmd_ready = 1;
    @(negedge clk);
    dn_cmd_ready = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int a0;
    int lat;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    chk("R1 req_ready in reset", up_req_ready, 1);
    chk("R1 rsp_valid in reset", up_rsp_valid, 0);
    chk("R1 cmd_valid in reset", dn_cmd_valid, 0);
    chk("R1 sticky in reset", tmo_sticky, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", tmo_irq, 0);
    cmp_on = 1;

    // normal transfer with response back-pressure, tick 4X
    tick_sel = 3'd2;
    send(0, 16'hA5A5, a0);
    chk("R2 command data", dn_cmd_data, 16'hA5A5);
    accept_cmd();
    up_rsp_ready = 0;
    target_reply(16'h1234);
    chk("R3 response valid", up_rsp_valid, 1);
    chk("R3 response data", up_rsp_data, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R3 held under back-pressure", up_rsp_valid, 1);
    chk("R3 held data", up_rsp_data, 16'h1234);
    up_rsp_ready = 1;
    @(negedge clk);

    // local register read
    cmd_seen = 0;
    send(1, 16'hFFFF, a0);
    chk("R4 local answered", up_rsp_valid, 1);
    chk("R4 local word", up_rsp_data, 16'h0002);
    chk("R4 local err", up_rsp_err, 0);
    chk("R4 not sent to target", cmd_seen, 0);
    @(negedge clk);

    // disabled codes never time out
    tick_sel = 3'd0;
    send(0, 16'h0001, a0);
    accept_cmd();
    repeat (300) @(negedge clk);
    chk("R5 code 0 no timeout", tmo_sticky, 0);
    tick_sel = 3'd5;
    repeat (200) @(negedge clk);
    chk("R5 code 5 no timeout", tmo_sticky, 0);
    target_reply(16'h0BEE);
    chk("R5 late reply clean", up_rsp_err, 0);
    @(negedge clk);

    // coincidence: response in the cycle of the second 1X tick
    tick_sel = 3'd1;
    send(0, 16'h0007, a0);
    accept_cmd();
    while (!(m_ph == 2 && m_ticks == 1 && tick_in[0])) @(negedge clk);
    dn_rsp_data = 16'h7777; dn_rsp_valid = 1;
    @(negedge clk);
    dn_rsp_valid = 0;
    chk("R7 response wins valid", up_rsp_valid, 1);
    chk("R7 response wins err", up_rsp_err, 0);
    chk("R7 response data", up_rsp_data, 16'h7777);
    chk("R7 no sticky", tmo_sticky, 0);
    chk("R7 no event", tmo_irq, 0);
    @(negedge clk);

    // target never accepts, 1X tick
    send(0, 16'h00C3, a0);
    wait_rsp(40);
    lat = cyc - a0;
    chk("R6 timeout err response", up_rsp_err, 1);
    chk("R6 window low", lat >= 8, 1);
    chk("R6 window high", lat <= 17, 1);
    chk("R8 event with error", tmo_irq, 1);
    chk("R8 sticky set", tmo_sticky, 1);
    @(negedge clk);
    chk("R8 event one cycle", tmo_irq, 0);

    // error state behaviour
    cmd_seen = 0;
    send(0, 16'h5555, a0);
    lat = cyc - a0;
    chk("R9 error reply latency", lat, 1);
    chk("R9 error reply flag", up_rsp_err, 1);
    @(negedge clk);
    chk("R9 target ready held", dn_rsp_ready, 1);
    target_reply(16'h9999);
    repeat (3) @(negedge clk);
    chk("R9 stray reply absorbed", up_rsp_valid, 0);
    chk("R9 no command", cmd_seen, 0);
    send(1, 16'h0000, a0);
    chk("R4 local in error state", up_rsp_data, 16'h0009);
    chk("R4 local err in error state", up_rsp_err, 0);
    @(negedge clk);

    // agent soft reset
    agent_srst = 1;
    @(negedge clk);
    agent_srst = 0;
    chk("R10 sticky cleared", tmo_sticky, 0);
    chk("R10 idle", up_req_ready, 1);
    tick_sel = 3'd2;
    send(0, 16'h2468, a0);
    chk("R10 forwarding again", dn_cmd_valid, 1);
    accept_cmd();
    target_reply(16'h1357);
    chk("R10 clean reply", up_rsp_data, 16'h1357);
    @(negedge clk);

    // 4X tick time-out, accepted but never answered
    send(0, 16'h0042, a0);
    accept_cmd();
    wait_rsp(200);
    lat = cyc - a0;
    chk("R5 4X window low", lat >= 32, 1);
    chk("R5 4X window high", lat <= 65, 1);
    chk("R6 4X error", up_rsp_err, 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule